// File: doc/BRIEF.md
# Once-per-second update cycle controller

This block paces the seconds of a calendar clock. A prescaled timebase enable (`tick`) advances an internal sub-second phase counter, and once per `TICKS_PER_SEC` ticks the block emits a single-cycle `adv` strobe. The time counters advance on that strobe. For a fixed number of ticks before each strobe it raises `uip`, so that software can see that the time registers are about to change. On the edge where `uip` drops it sets the update-ended flag `uf`.

Software reaches the block through four narrow write and read strobes. These are the three-bit divider control field, the freeze bit (`set_mode`), the update interrupt enable, and a read of the status register. A divider field value of 11x holds the phase at zero. Writing 010 releases it at the half-second point, so the first update comes half a second later. While the freeze bit is set the phase keeps running, but no update, `uip` or `uf` is produced. The calendar arithmetic, bus decode and periodic rate generator are not part of this block.

Top module: `upd_cycle_ctl`

## Requirements
- R1: `uip` is high for exactly `UIP_TICKS` ticks, which are the phase values `TICKS_PER_SEC-UIP_TICKS` through `TICKS_PER_SEC-1`, immediately before each update. The defaults of 32768 and 73 give about 2.2 ms at a 32.768 kHz tick, which lies between 244 µs and 3 ms.
- R2: `uf` rises on the same edge on which `uip` falls, and `adv` is high for exactly that one cycle.
- R3: A `stat_rd` strobe clears `uf` and `irq`. If an update lands on the same edge, `uf` and `irq` stay set.
- R4: Updates repeat every `TICKS_PER_SEC` ticks. The phase advances only in cycles where `tick` is 1.
- R5: Writing 110 or 111 to the divider field enters divider reset. In that state the phase is held at 0 and there is no `uip` and no update. Writing 010 while in reset leaves reset at the half phase, so the first update comes `TICKS_PER_SEC/2` ticks later. Writing any other code has no effect.
- R6: While `set_mode` is 1 there is no `uip`, no `adv` and no `uf`, but the phase keeps counting. After `set_mode` is cleared, updates resume on the same phase.
- R7: Writing 1 to the freeze bit clears `uie` and `uip` on that edge. This takes priority over a `uie` write in the same cycle.
- R8: `irq` is set when an update occurs while `uie` is 1, or when `uie` is enabled while `uf` is set. It then stays high until a status read.
- R9: After reset, all outputs are 0 and the phase is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled timebase enable |
| div_wr | input | 1 | Divider field write strobe |
| div_val | input | 3 | Divider field value |
| set_wr | input | 1 | Freeze bit write strobe |
| set_val | input | 1 | Freeze bit value |
| uie_wr | input | 1 | Update interrupt enable write strobe |
| uie_val | input | 1 | Update interrupt enable value |
| stat_rd | input | 1 | Status register read strobe |
| uip | output | 1 | Update in progress |
| uf | output | 1 | Update-ended flag |
| irq | output | 1 | Interrupt request (summary flag) |
| uie | output | 1 | Update interrupt enable state |
| set_mode | output | 1 | Freeze bit state |
| div_rst | output | 1 | Divider reset active |
| adv | output | 1 | One-cycle time advance strobe |

## Verification
An update and a status read can fall on the same clock edge. In that case the read's clear competes with the setting of `uf` and `irq`. The bench drives `stat_rd` in the cycle whose closing edge is a scheduled update, and requires that both flags are still high afterwards. A later plain read must then clear them.

// File: rtl/upd_cycle_ctl.sv
module upd_cycle_ctl #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 73
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       div_wr,
  input  logic [2:0] div_val,
  input  logic       set_wr,
  input  logic       set_val,
  input  logic       uie_wr,
  input  logic       uie_val,
  input  logic       stat_rd,
  output logic       uip,
  output logic       uf,
  output logic       irq,
  output logic       uie,
  output logic       set_mode,
  output logic       div_rst,
  output logic       adv
);

  localparam int PW = $clog2(TICKS_PER_SEC);
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);
  localparam logic [PW-1:0] WIN  = PW'(TICKS_PER_SEC - UIP_TICKS);
  localparam logic [PW-1:0] HALF = PW'(TICKS_PER_SEC / 2);

  logic [PW-1:0] ph, ph_nx;

  wire div_enter  = div_wr && (div_val[2:1] == 2'b11);
  wire div_leave  = div_wr && (div_val == 3'b010) && div_rst;
  wire div_rst_nx = div_enter ? 1'b1 : (div_leave ? 1'b0 : div_rst);
  wire set_on     = set_wr && set_val;
  wire set_nx     = set_wr ? set_val : set_mode;
  wire wrap       = tick && (ph == LAST);
  wire upd        = uip && wrap && !set_on && !div_enter;
  wire uie_nx     = set_on ? 1'b0 : (uie_wr ? uie_val : uie);
  wire uip_nx     = !div_rst_nx && !set_nx && (ph_nx >= WIN);
  wire uf_nx      = upd || (uf && !stat_rd);
  wire irq_nx     = (upd && uie_nx) ||
                    (uf && !stat_rd && uie_nx && !uie) ||
                    (irq && !stat_rd);

  always_comb begin
    if (div_rst_nx)     ph_nx = '0;
    else if (div_leave) ph_nx = HALF;
    else if (wrap)      ph_nx = '0;
    else if (tick)      ph_nx = ph + 1'b1;
    else                ph_nx = ph;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= '0;
      div_rst  <= 1'b0;
      set_mode <= 1'b0;
      uie      <= 1'b0;
      uip      <= 1'b0;
      uf       <= 1'b0;
      irq      <= 1'b0;
      adv      <= 1'b0;
    end else begin
      ph       <= ph_nx;
      div_rst  <= div_rst_nx;
      set_mode <= set_nx;
      uie      <= uie_nx;
      uip      <= uip_nx;
      uf       <= uf_nx;
      irq      <= irq_nx;
      adv      <= upd;
    end
  end

  a_r2_uf_on_uip_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uf) |-> $fell(uip));
  a_r2_adv_single: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> !adv);
  a_r5_div_rst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    div_rst |-> (!uip && !adv));
  a_r6_set_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    set_mode |-> (!uip && !adv));
  a_r7_set_clears_uie: assert property (@(posedge clk) disable iff (!rst_n)
    (set_wr && set_val) |=> (!uie && !uip));
  a_r8_irq_needs_uf: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> uf);
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(uip && tick)) |=> (!uf && !irq));

endmodule

// File: tb/upd_cycle_ctl_tb_top.sv
module upd_cycle_ctl_tb_top;
  localparam int TPS = 100;
  localparam int UIPT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic div_wr = 1'b0;
  logic [2:0] div_val = 3'b000;
  logic set_wr = 1'b0, set_val = 1'b0;
  logic uie_wr = 1'b0, uie_val = 1'b0;
  logic stat_rd = 1'b0;
  logic uip, uf, irq, uie, set_mode, div_rst, adv;

  int cyc = 0;
  int nchk = 0;
  int nfail = 0;
  int nadv = 0;
  int uip_run = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  upd_cycle_ctl #(.TICKS_PER_SEC(TPS), .UIP_TICKS(UIPT)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .div_wr(div_wr), .div_val(div_val),
    .set_wr(set_wr), .set_val(set_val), .uie_wr(uie_wr), .uie_val(uie_val),
    .stat_rd(stat_rd), .uip(uip), .uf(uf), .irq(irq), .uie(uie),
    .set_mode(set_mode), .div_rst(div_rst), .adv(adv));

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic at(int n);
    while (cyc < n) @(negedge clk);
  endtask

  // monitor: pops expected update cycles and measures UIP windows
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (adv) begin
        nadv++;
        if (exp_q.size() == 0) chk("R4 unexpected update", cyc, -1);
        else chk("R4 update cycle", cyc, exp_q.pop_front());
      end
      if (uip) uip_run++;
      else if (uip_run != 0) begin
        chk("R1 uip width", uip_run, UIPT);
        uip_run = 0;
      end
    end
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      done = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog cyc=%0d actual=0 expected=1", cyc);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R9 uip", uip, 0); chk("R9 uf", uf, 0); chk("R9 irq", irq, 0);
    chk("R9 adv", adv, 0); chk("R9 uie", uie, 0);
    chk("R9 set", set_mode, 0); chk("R9 div", div_rst, 0);

    exp_q.push_back(100);
    at(91);  chk("R1 uip before window", uip, 0);
    at(95);  chk("R1 uip in window", uip, 1);
    at(100); chk("R2 uf at update", uf, 1); chk("R2 uip dropped", uip, 0);
    stat_rd = 1'b1; at(101); stat_rd = 1'b0;
    chk("R3 read clears uf", uf, 0);

    at(110); uie_wr = 1'b1; uie_val = 1'b1; at(111); uie_wr = 1'b0;
    chk("R8 uie set", uie, 1);
    exp_q.push_back(200);
    at(200); chk("R8 uf", uf, 1); chk("R8 irq", irq, 1);
    at(205); stat_rd = 1'b1; at(206); stat_rd = 1'b0;
    chk("R3 read clears irq", irq, 0); chk("R3 read clears uf", uf, 0);

    exp_q.push_back(300);
    at(299); stat_rd = 1'b1; at(300); stat_rd = 1'b0;
    chk("R3 update beats read uf", uf, 1); chk("R3 update beats read irq", irq, 1);
    at(301); stat_rd = 1'b1; at(302); stat_rd = 1'b0;
    chk("R3 later read clears", uf, 0);

    at(310); set_wr = 1'b1; set_val = 1'b1; at(311); set_wr = 1'b0;
    chk("R7 set clears uie", uie, 0); chk("R7 set on", set_mode, 1);
    at(395); chk("R6 no uip while set", uip, 0);
    at(400); chk("R6 no uf while set", uf, 0);
    at(420); set_wr = 1'b1; set_val = 1'b0; at(421); set_wr = 1'b0;
    exp_q.push_back(500);
    at(495); chk("R6 phase kept uip", uip, 1);
    at(500); chk("R6 update resumes", uf, 1);
    at(501); stat_rd = 1'b1; at(502); stat_rd = 1'b0;

    at(510); div_wr = 1'b1; div_val = 3'b110; at(511); div_wr = 1'b0;
    chk("R5 enter reset", div_rst, 1);
    at(595); chk("R5 no uip in reset", uip, 0);
    at(600); chk("R5 no uf in reset", uf, 0);
    at(650); div_wr = 1'b1; div_val = 3'b111; at(651); div_wr = 1'b0;
    chk("R5 111 keeps reset", div_rst, 1);
    at(700); div_wr = 1'b1; div_val = 3'b010; at(701); div_wr = 1'b0;
    chk("R5 leave reset", div_rst, 0);
    exp_q.push_back(751);
    at(750); chk("R5 not yet", uf, 0);
    at(751); chk("R5 half second update", uf, 1);
    at(760); div_wr = 1'b1; div_val = 3'b000; at(761); div_wr = 1'b0;
    chk("R5 other code ignored", div_rst, 0);
    exp_q.push_back(851);

    at(860); tick = 1'b0; at(890); tick = 1'b1;
    exp_q.push_back(981);
    at(1000);
    chk("R4 all updates seen", exp_q.size(), 0);
    chk("R4 update count", nadv, 7);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule